// File: doc/BRIEF.md
# USB IN Token Response Selector

This block picks the answer one device endpoint gives each time the host polls it with an IN token. On a token it looks at four things: whether a stall has been requested, whether the transmit FIFO holds data, whether a zero-length packet has been requested, and how the endpoint is configured (its transfer type and its largest packet size). From these it answers with a STALL handshake, a data packet of zero bytes, a data packet of a computed length, or a NAK. It then follows the packet until the transaction finishes and tells the register block when it finished, so that the request bits can clear themselves.

The answer comes out one clock after the token. The order of choice is fixed: a pending stall wins first, then a pending zero-length request on an empty FIFO, then plain data, and NAK is the fallback. A zero-length packet tells the host that a transfer whose data ended exactly on a packet boundary is over. The request that caused it is released only after the host acknowledges that packet. Isochronous endpoints have no handshake phase, so their transaction completes as soon as the packet has been sent. The controller has three states: `ST_IDLE`, `ST_SEND` and `ST_WAIT_HS`. The transitions are:
- poll-to-send (`ST_IDLE`→`ST_SEND`, on a data or zero-length answer)
- poll-stay (`ST_IDLE`→`ST_IDLE`, on STALL or NAK)
- sent-iso (`ST_SEND`→`ST_IDLE`)
- sent-wait (`ST_SEND`→`ST_WAIT_HS`)
- ack (`ST_WAIT_HS`→`ST_IDLE`, with completion)
- timeout (`ST_WAIT_HS`→`ST_IDLE`, with no completion)

Top module: `usb_in_resp`

## Requirements
- R1: After reset `resp_vld`, `stall_taken`, `done_pulse` and `zlp_clr` are 0, `resp_kind` is 0 and `tx_len` is 0.
- R2: A token taken in idle while `stall_req` is high produces, in the next cycle, `resp_vld`=1, `resp_kind`=3 (STALL) and `stall_taken`=1. This holds whatever the FIFO count and the zero-length request are. `stall_taken` lasts one cycle, and the block is idle again straight away.
- R3: A token with `stall_req` low, `fifo_cnt`=0 and `zlp_req` high is answered with `resp_kind`=2 (zero-length data) and `tx_len`=0.
- R4: A token with `stall_req` low, `fifo_cnt`=0 and `zlp_req` low is answered with `resp_kind`=0 (NAK) and `tx_len`=0. No completion follows, and the next token is accepted.
- R5: For a non-empty FIFO on an endpoint that is not isochronous, the answer is `resp_kind`=1 (data) with `tx_len` = min(`fifo_cnt`, 8<<`max_sel`). The `max_sel` codes are 0:8, 1:16, 2:32 and 3:64 bytes.
- R6: On an isochronous endpoint (`ep_type`=1) `max_sel` is ignored and `tx_len` equals `fifo_cnt`.
- R7: For a data or zero-length answer on an endpoint that is not isochronous, `tx_done` alone gives no completion. `done_pulse` rises for one cycle in the cycle after `hs_ack`.
- R8: If `hs_tmo` arrives while the block waits for the handshake, no `done_pulse` and no `zlp_clr` follow, and the next token is answered again.
- R9: On an isochronous endpoint `done_pulse` is raised in the cycle after `tx_done`, with no handshake input needed.
- R10: A token that arrives while a packet is being sent or a handshake is awaited is ignored, and no `resp_vld` follows.
- R11: `zlp_clr` comes together with `done_pulse` only when the completed packet was a zero-length answer. A data packet sent while `zlp_req` is pending leaves `zlp_clr` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_vld | input | 1 | One-cycle pulse for an IN token addressed to this endpoint |
| ep_type | input | 2 | Transfer type: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| max_sel | input | 2 | Largest packet code, size 8<<code bytes |
| fifo_cnt | input | CNT_W | Bytes waiting in the transmit FIFO |
| stall_req | input | 1 | Pending forced-stall request |
| zlp_req | input | 1 | Pending zero-length-send request |
| tx_done | input | 1 | Pulse: the chosen packet has left the serializer |
| hs_ack | input | 1 | Pulse: host acknowledged the packet |
| hs_tmo | input | 1 | Pulse: handshake wait timed out |
| resp_vld | output | 1 | Answer valid, one cycle after the token |
| resp_kind | output | 2 | Answer: 0 NAK, 1 data, 2 zero-length data, 3 STALL |
| tx_len | output | CNT_W | Bytes to send with the answer |
| stall_taken | output | 1 | Pulse: the stall request has been used |
| done_pulse | output | 1 | Pulse: the transaction completed successfully |
| zlp_clr | output | 1 | Pulse: the zero-length request may be cleared |

## Verification
A stuck or wrong state shows up at the ports within one or two clocks. If the block stays in `ST_SEND` or `ST_WAIT_HS`, the next token gets no `resp_vld`. If it leaves early, a token is answered while the block should still be busy. If it returns to idle on a timeout in the wrong way, a stray `done_pulse` appears in the cycle after `hs_tmo`. A stale record of the packet kind or endpoint type surfaces as `zlp_clr` after a data packet, or as a completion that comes at the wrong handshake step. The bench drives each of these paths and samples in the exact cycle after the causing input.

// File: rtl/usb_in_resp_pkg.sv
package usb_in_resp_pkg;

    typedef enum logic [1:0] {
        RK_NAK   = 2'd0,
        RK_DATA  = 2'd1,
        RK_ZLP   = 2'd2,
        RK_STALL = 2'd3
    } resp_kind_e;

    typedef enum logic [1:0] {
        EP_CTRL = 2'd0,
        EP_ISO  = 2'd1,
        EP_BULK = 2'd2,
        EP_INTR = 2'd3
    } ep_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEND    = 2'd1,
        ST_WAIT_HS = 2'd2
    } state_e;

endpackage

// File: rtl/in_resp_pick.sv
module in_resp_pick
    import usb_in_resp_pkg::*;
#(
    parameter int CNT_W    = 11,
    parameter int BASE_PKT = 8,
    parameter int N_SIZES  = 4
) (
    input  logic [1:0]       ep_type,
    input  logic [1:0]       max_sel,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic             stall_req,
    input  logic             zlp_req,
    output resp_kind_e       pick_kind,
    output logic [CNT_W-1:0] pick_len,
    output logic             pick_iso
);
    localparam int SEL_W = $clog2(N_SIZES);

    logic [CNT_W-1:0] size_tab [N_SIZES];
    logic [CNT_W-1:0] cap;
    logic             fifo_empty;

    // largest-packet table, one entry per size code
    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        assign size_tab[g] = CNT_W'(BASE_PKT << g);
    end

    assign cap        = size_tab[max_sel[SEL_W-1:0]];
    assign fifo_empty = (fifo_cnt == '0);
    assign pick_iso   = (ep_kind_e'(ep_type) == EP_ISO);

    // fixed priority: stall, zero-length on empty, NAK on empty, data
    always_comb begin
        pick_kind = RK_DATA;
        pick_len  = '0;
        if (stall_req) begin
            pick_kind = RK_STALL;
        end else if (fifo_empty && zlp_req) begin
            pick_kind = RK_ZLP;
        end else if (fifo_empty) begin
            pick_kind = RK_NAK;
        end else if (pick_iso) begin
            pick_len  = fifo_cnt;
        end else begin
            pick_len  = (fifo_cnt < cap) ? fifo_cnt : cap;
        end
    end

    // R4: an empty FIFO never yields a non-zero length
    always_comb begin
        if (fifo_empty) assert (pick_len == '0);
    end

endmodule

// File: rtl/in_resp_fsm.sv
module in_resp_fsm
    import usb_in_resp_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_vld,
    input  resp_kind_e       pick_kind,
    input  logic [CNT_W-1:0] pick_len,
    input  logic             pick_iso,
    input  logic             stall_req,
    input  logic             tx_done,
    input  logic             hs_ack,
    input  logic             hs_tmo,
    output logic             resp_vld,
    output resp_kind_e       resp_kind,
    output logic [CNT_W-1:0] tx_len,
    output logic             stall_taken,
    output logic             done_pulse,
    output logic             zlp_clr
);
    state_e state, state_nxt;
    logic   cur_zlp, cur_iso;
    logic   poll, fin_ok;

    assign poll   = (state == ST_IDLE) && tok_vld;
    assign fin_ok = ((state == ST_SEND) && tx_done && cur_iso) ||
                    ((state == ST_WAIT_HS) && hs_ack);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                // poll-to-send or poll-stay
                if (tok_vld && (pick_kind == RK_DATA || pick_kind == RK_ZLP))
                    state_nxt = ST_SEND;
            end
            ST_SEND: begin
                // sent-iso or sent-wait
                if (tx_done) state_nxt = cur_iso ? ST_IDLE : ST_WAIT_HS;
            end
            ST_WAIT_HS: begin
                // ack or timeout
                if (hs_ack || hs_tmo) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register and the record of the packet in flight
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_zlp <= 1'b0;
            cur_iso <= 1'b0;
        end else begin
            state <= state_nxt;
            if (poll) begin
                cur_zlp <= (pick_kind == RK_ZLP);
                cur_iso <= pick_iso;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_vld    <= 1'b0;
            resp_kind   <= RK_NAK;
            tx_len      <= '0;
            stall_taken <= 1'b0;
            done_pulse  <= 1'b0;
            zlp_clr     <= 1'b0;
        end else begin
            resp_vld    <= poll;
            resp_kind   <= poll ? pick_kind : RK_NAK;
            tx_len      <= poll ? pick_len : '0;
            stall_taken <= poll && (pick_kind == RK_STALL);
            done_pulse  <= fin_ok;
            zlp_clr     <= fin_ok && cur_zlp;
        end
    end

    p_stall_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tok_vld && stall_req) |=>
            (resp_vld && resp_kind == RK_STALL && stall_taken));

    p_stall_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stall_taken |=> !stall_taken);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    p_tmo_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_HS && hs_tmo && !hs_ack) |=> (!done_pulse && !zlp_clr));

    p_busy_deaf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> !resp_vld);

    p_zclr_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        zlp_clr |-> done_pulse);

endmodule

// File: rtl/usb_in_resp.sv
module usb_in_resp
    import usb_in_resp_pkg::*;
#(
    parameter int CNT_W    = 11,
    parameter int BASE_PKT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_vld,
    input  logic [1:0]       ep_type,
    input  logic [1:0]       max_sel,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic             stall_req,
    input  logic             zlp_req,
    input  logic             tx_done,
    input  logic             hs_ack,
    input  logic             hs_tmo,
    output logic             resp_vld,
    output logic [1:0]       resp_kind,
    output logic [CNT_W-1:0] tx_len,
    output logic             stall_taken,
    output logic             done_pulse,
    output logic             zlp_clr
);
    resp_kind_e       pick_kind, kind_q;
    logic [CNT_W-1:0] pick_len;
    logic             pick_iso;

    in_resp_pick #(.CNT_W(CNT_W), .BASE_PKT(BASE_PKT), .N_SIZES(4)) pick_i (
        .ep_type   (ep_type),
        .max_sel   (max_sel),
        .fifo_cnt  (fifo_cnt),
        .stall_req (stall_req),
        .zlp_req   (zlp_req),
        .pick_kind (pick_kind),
        .pick_len  (pick_len),
        .pick_iso  (pick_iso)
    );

    in_resp_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tok_vld     (tok_vld),
        .pick_kind   (pick_kind),
        .pick_len    (pick_len),
        .pick_iso    (pick_iso),
        .stall_req   (stall_req),
        .tx_done     (tx_done),
        .hs_ack      (hs_ack),
        .hs_tmo      (hs_tmo),
        .resp_vld    (resp_vld),
        .resp_kind   (kind_q),
        .tx_len      (tx_len),
        .stall_taken (stall_taken),
        .done_pulse  (done_pulse),
        .zlp_clr     (zlp_clr)
    );

    assign resp_kind = kind_q;

    p_len_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_kind == RK_DATA && $past(ep_type) != EP_ISO) |->
            (tx_len <= CNT_W'(BASE_PKT << $past(max_sel))));

    p_nodata_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_kind != RK_DATA) |-> (tx_len == '0));

    p_iso_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && resp_kind == RK_DATA && $past(ep_type) == EP_ISO) |->
            (tx_len == $past(fifo_cnt)));

endmodule

// File: tb/usb_in_resp_tb_top.sv
module usb_in_resp_tb_top;
    localparam int CW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tok_vld = 1'b0;
    logic [1:0]    ep_type = 2'd2;
    logic [1:0]    max_sel = 2'd0;
    logic [CW-1:0] fifo_cnt = '0;
    logic          stall_req = 1'b0;
    logic          zlp_req = 1'b0;
    logic          tx_done = 1'b0;
    logic          hs_ack = 1'b0;
    logic          hs_tmo = 1'b0;
    logic          resp_vld, stall_taken, done_pulse, zlp_clr;
    logic [1:0]    resp_kind;
    logic [CW-1:0] tx_len;

    int total = 0;
    int bad = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    usb_in_resp #(.CNT_W(CW), .BASE_PKT(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .tok_vld(tok_vld), .ep_type(ep_type),
        .max_sel(max_sel), .fifo_cnt(fifo_cnt), .stall_req(stall_req),
        .zlp_req(zlp_req), .tx_done(tx_done), .hs_ack(hs_ack), .hs_tmo(hs_tmo),
        .resp_vld(resp_vld), .resp_kind(resp_kind), .tx_len(tx_len),
        .stall_taken(stall_taken), .done_pulse(done_pulse), .zlp_clr(zlp_clr)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setup(input logic [1:0] t, input logic [1:0] m, input int cnt,
                         input logic st, input logic z);
        ep_type = t; max_sel = m; fifo_cnt = CW'(cnt); stall_req = st; zlp_req = z;
    endtask

    // token on one edge; answer is visible after it
    task automatic poll();
        tok_vld = 1'b1;
        @(negedge clk);
        tok_vld = 1'b0;
    endtask

    task automatic pulse_tx();
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic pulse_ack();
        hs_ack = 1'b1;
        @(negedge clk);
        hs_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 resp_vld", int'(resp_vld), 0);
        check("R1 resp_kind", int'(resp_kind), 0);
        check("R1 tx_len", int'(tx_len), 0);
        check("R1 pulses", int'({stall_taken, done_pulse, zlp_clr}), 0);
    endtask

    task automatic t_bulk_data();
        setup(2'd2, 2'd1, 100, 1'b0, 1'b0);
        poll();
        check("R5 vld", int'(resp_vld), 1);
        check("R5 kind", int'(resp_kind), 1);
        check("R5 len capped 16", int'(tx_len), 16);
        pulse_tx();
        check("R7 no done before ack", int'(done_pulse), 0);
        @(negedge clk);
        check("R7 still waiting", int'(done_pulse), 0);
        pulse_ack();
        check("R7 done after ack", int'(done_pulse), 1);
        check("R11 no zlp_clr on data", int'(zlp_clr), 0);
        @(negedge clk);
        check("R7 done one cycle", int'(done_pulse), 0);
    endtask

    task automatic t_short_and_equal();
        setup(2'd3, 2'd3, 5, 1'b0, 1'b0);
        poll();
        check("R5 short len", int'(tx_len), 5);
        pulse_tx(); pulse_ack();
        setup(2'd0, 2'd2, 32, 1'b0, 1'b0);
        poll();
        check("R5 len equal max 32", int'(tx_len), 32);
        pulse_tx(); pulse_ack();
        @(negedge clk);
    endtask

    task automatic t_nak();
        setup(2'd2, 2'd0, 0, 1'b0, 1'b0);
        poll();
        check("R4 vld", int'(resp_vld), 1);
        check("R4 kind NAK", int'(resp_kind), 0);
        check("R4 len", int'(tx_len), 0);
        poll();
        check("R4 next token accepted", int'(resp_vld), 1);
        check("R4 no completion", int'(done_pulse), 0);
        @(negedge clk);
    endtask

    task automatic t_zlp();
        setup(2'd2, 2'd3, 0, 1'b0, 1'b1);
        poll();
        check("R3 kind ZLP", int'(resp_kind), 2);
        check("R3 len 0", int'(tx_len), 0);
        pulse_tx();
        check("R11 no clr before ack", int'(zlp_clr), 0);
        pulse_ack();
        check("R7 zlp done", int'(done_pulse), 1);
        check("R11 zlp_clr", int'(zlp_clr), 1);
        zlp_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_stall();
        setup(2'd2, 2'd3, 30, 1'b1, 1'b1);
        poll();
        check("R2 kind STALL", int'(resp_kind), 3);
        check("R2 stall_taken", int'(stall_taken), 1);
        check("R2 len 0", int'(tx_len), 0);
        stall_req = 1'b0;
        zlp_req = 1'b0;
        @(negedge clk);
        check("R2 stall_taken one cycle", int'(stall_taken), 0);
        poll();
        check("R2 idle again after stall", int'(resp_kind), 1);
        pulse_tx(); pulse_ack();
    endtask

    task automatic t_iso();
        setup(2'd1, 2'd0, 200, 1'b0, 1'b0);
        poll();
        check("R6 iso len ignores max", int'(tx_len), 200);
        pulse_tx();
        check("R9 iso done after tx", int'(done_pulse), 1);
        poll();
        check("R9 iso back idle", int'(resp_vld), 1);
        pulse_tx();
        @(negedge clk);
    endtask

    task automatic t_timeout();
        setup(2'd2, 2'd0, 20, 1'b0, 1'b0);
        poll();
        check("R5 len capped 8", int'(tx_len), 8);
        pulse_tx();
        hs_tmo = 1'b1;
        @(negedge clk);
        hs_tmo = 1'b0;
        check("R8 no done on timeout", int'(done_pulse), 0);
        check("R8 no zlp_clr on timeout", int'(zlp_clr), 0);
        poll();
        check("R8 retry answered", int'(resp_vld), 1);
        pulse_tx(); pulse_ack();
    endtask

    task automatic t_busy();
        setup(2'd2, 2'd1, 40, 1'b0, 1'b0);
        poll();
        poll();
        check("R10 ignored in send", int'(resp_vld), 0);
        pulse_tx();
        poll();
        check("R10 ignored in wait", int'(resp_vld), 0);
        pulse_ack();
        check("R10 still completes", int'(done_pulse), 1);
    endtask

    task automatic t_data_with_zlp();
        setup(2'd2, 2'd2, 10, 1'b0, 1'b1);
        poll();
        check("R11 data wins over zlp", int'(resp_kind), 1);
        check("R11 len", int'(tx_len), 10);
        pulse_tx(); pulse_ack();
        check("R11 done", int'(done_pulse), 1);
        check("R11 zlp kept", int'(zlp_clr), 0);
        zlp_req = 1'b0;
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bulk_data();
        t_short_and_equal();
        t_nak();
        t_zlp();
        t_stall();
        t_iso();
        t_timeout();
        t_busy();
        t_data_with_zlp();
        repeat (2) @(negedge clk);
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

endmodule